// File: doc/BRIEF.md
# Converter Serial Port Responder

This block is the peripheral end of a 16-clock serial frame between a host and a 12-bit, multi-channel converter. Each frame does two things at once. The host shifts a control word in on DIN, and the block shifts out the latest conversion result tagged with the number of the channel it came from. The chip-select, serial-clock and data pins are resampled into the block's own clock domain. Bit timing is recovered from the edges of the resampled serial clock.

The block keeps a stored channel address and a data coding selection. It publishes the stored channel so the converter knows which input to convert next. The converter returns that channel's sample on a parallel bus. The block captures the sample, and the channel tag, at the moment chip select falls. A control word replaces the stored settings only when its leading bit requests a write and the frame runs to completion.

Top module: `adc_port_resp`

## Requirements
- R1: While chip select is high, and directly after reset, `dout_oe` is 0 and `dout` is 0.
- R2: After chip select falls, `dout_oe` becomes 1 and the first output bit is presented before the first SCLK falling edge.
- R3: The 16-bit output word is two 0 bits, then the 2-bit channel address, then the 12 data bits, MSB first. After each SCLK falling edge the next bit appears on `dout`.
- R4: DIN is captured on SCLK falling edges, 16 bits per frame, MSB first. Frame position 0 (first bit) is the write flag, positions 4 and 5 are the channel address (MSB first), and position 10 is the coding bit. All other positions are ignored.
- R5: When a completed frame's write flag is 1, the captured address and coding bit become the stored settings, visible on `chan_sel` and `coding`.
- R6: When a completed frame's write flag is 0, the stored address and coding bit are unchanged.
- R7: `dout_oe` returns to 0 after the 16th SCLK falling edge of a frame.
- R8: If chip select rises before the 16th SCLK falling edge, the frame is dropped. `dout_oe` goes to 0, the stored settings are unchanged, and the next frame starts again at bit 0.
- R9: The result in a frame is the `sample_data` value and channel address present when that frame's chip select fell. Later changes to `sample_data` do not alter it.
- R10: With coding 0 the data bits are the sample in straight binary. With coding 1 the sample's MSB is inverted (two's complement).
- R11: Reset sets the stored channel address to 0 and the coding to 0.
- R12: SCLK falling edges after the 16th, within the same chip-select low period, do not re-enable `dout_oe` and do not capture DIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are resampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Frame select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial control word from the host |
| sample_data | input | DATA_W | Converter result for the channel shown on `chan_sel` |
| dout | output | 1 | Serial result bit, 0 when not enabled |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| chan_sel | output | ADDR_W | Stored channel address for the next conversion |
| coding | output | 1 | Stored data coding: 0 straight binary, 1 two's complement |

## Verification
The bench builds the block with its default parameters: a 12-bit sample, a 2-bit channel address, two resampling stages, and the address and coding fields at positions 4-5 and 10. With these values all four channels and both codings appear in the returned words. Frames are dropped after 7 and after 15 falling edges, which reaches the one-edge-short boundary of the counter. The serial clock runs at several block clocks per half period, so the resampling delay stays inside each bit slot. This lets the bench predict every bit at the falling edge that follows it.

// File: rtl/adc_port_pkg.sv
// Shared definitions for the converter serial port responder.
// Assumes: frame = lead zeros + channel address + sample bits.
package adc_port_pkg;

    // Number of constant 0 bits leading every output word.
    localparam int LEAD_ZEROS = 2;

    // Data coding applied to the returned sample.
    typedef enum logic {
        CODE_STRAIGHT = 1'b0,
        CODE_TWOS     = 1'b1
    } code_e;

endpackage

// File: rtl/adc_port_sync.sv
// Multi-bit pin resampler: STAGES flops per bit into the clk domain.
// Assumes: each bit is independent; no bus coherency is required.
module adc_port_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= pins_in;
                end
            end else begin : g_next
                // Later stages settle the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign pins_out = stage_q[STAGES-1];

endmodule

// File: rtl/adc_port_rx.sv
// Frame controller: detects select/clock edges, counts bits, captures the
// control word and holds the stored channel address and coding.
// Assumes: inputs already resampled; SCLK idles high; bits taken on falls.
module adc_port_rx
    import adc_port_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int FRAME_BITS = 16,
    parameter int ADDR_POS   = 4,
    parameter int CODE_POS   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              frame_load,
    output logic              bit_shift,
    output logic              frame_active,
    output logic [ADDR_W-1:0] cfg_addr,
    output code_e             cfg_code
);

    localparam int                CNT_W    = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam int                WR_IDX   = FRAME_BITS - 1;
    localparam int                ADDR_MSB = FRAME_BITS - 1 - ADDR_POS;
    localparam int                CODE_IDX = FRAME_BITS - 1 - CODE_POS;

    logic                  cs_q;
    logic                  sclk_q;
    logic                  cs_fall;
    logic                  cs_rise;
    logic                  sclk_fall;
    logic                  take_bit;
    logic                  done_q;
    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] rx_sr;

    // Previous resampled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n_s;
            sclk_q <= sclk_s;
        end
    end

    assign cs_fall   = cs_q & ~cs_n_s;
    assign cs_rise   = ~cs_q & cs_n_s;
    assign sclk_fall = sclk_q & ~sclk_s;
    assign take_bit  = sclk_fall & frame_active & ~cs_n_s;

    // Frame state: start on select fall, stop on 16th bit or early abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_active <= 1'b0;
            bit_cnt      <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cs_fall) begin
                frame_active <= 1'b1;
                bit_cnt      <= '0;
            end else if (cs_rise) begin
                frame_active <= 1'b0;
                bit_cnt      <= '0;
            end else if (take_bit) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    frame_active <= 1'b0;
                    done_q       <= 1'b1;
                end
            end
        end
    end

    // Control word shift register, first bit ends up in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_sr <= '0;
        else if (take_bit) rx_sr <= {rx_sr[FRAME_BITS-2:0], din_s};
    end

    // Stored settings: replaced only by a completed frame with write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr <= '0;
            cfg_code <= CODE_STRAIGHT;
        end else if (done_q && rx_sr[WR_IDX]) begin
            cfg_addr <= rx_sr[ADDR_MSB -: ADDR_W];
            cfg_code <= code_e'(rx_sr[CODE_IDX]);
        end
    end

    assign frame_load = cs_fall;
    assign bit_shift  = take_bit;

    // R1
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && cs_q) |-> !frame_active);

    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_active) |-> $past(cs_fall));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !cs_fall) |=> (!frame_active && !done_q));

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_addr, cfg_code}) |-> $past(done_q && rx_sr[WR_IDX]));

endmodule

// File: rtl/adc_port_tx.sv
// Result shifter: builds the tagged, coded output word when a frame starts
// and shifts it one bit per SCLK fall. Assumes load and shift never coincide.
module adc_port_tx
    import adc_port_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [ADDR_W-1:0] addr_in,
    input  code_e             code_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              bit_out
);

    localparam int FRAME_BITS = LEAD_ZEROS + ADDR_W + DATA_W;

    logic [DATA_W-1:0]     coded;
    logic [FRAME_BITS-1:0] frame_word;
    logic [FRAME_BITS-1:0] tx_sr;

    // Sample coding: two's complement flips only the sign position.
    always_comb begin
        coded = sample_in;
        if (code_in == CODE_TWOS) coded[DATA_W-1] = ~sample_in[DATA_W-1];
    end

    assign frame_word = {{LEAD_ZEROS{1'b0}}, addr_in, coded};

    // Output shift register: parallel load at frame start, MSB out first.
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_sr <= '0;
        else if (load)  tx_sr <= frame_word;
        else if (shift) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
    end

    assign bit_out = tx_sr[FRAME_BITS-1];

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !bit_out);

endmodule

// File: rtl/adc_port_resp.sv
// Converter serial port responder top: resamples the pins, runs the frame
// controller and the result shifter, and gates the serial output.
// Assumes: clk is several times faster than SCLK.
module adc_port_resp
    import adc_port_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_POS    = 4,
    parameter int CODE_POS    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] sample_data,
    output logic              dout,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] chan_sel,
    output logic              coding
);

    localparam int FRAME_BITS = LEAD_ZEROS + ADDR_W + DATA_W;

    logic [2:0]        pins_s;
    logic              frame_load;
    logic              bit_shift;
    logic              frame_active;
    logic              tx_bit;
    logic [ADDR_W-1:0] cfg_addr;
    code_e             cfg_code;

    adc_port_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  ({cs_n, sclk, din}),
        .pins_out (pins_s)
    );

    adc_port_rx #(
        .ADDR_W     (ADDR_W),
        .FRAME_BITS (FRAME_BITS),
        .ADDR_POS   (ADDR_POS),
        .CODE_POS   (CODE_POS)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_s       (pins_s[2]),
        .sclk_s       (pins_s[1]),
        .din_s        (pins_s[0]),
        .frame_load   (frame_load),
        .bit_shift    (bit_shift),
        .frame_active (frame_active),
        .cfg_addr     (cfg_addr),
        .cfg_code     (cfg_code)
    );

    adc_port_tx #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_load),
        .shift     (bit_shift),
        .addr_in   (cfg_addr),
        .code_in   (cfg_code),
        .sample_in (sample_data),
        .bit_out   (tx_bit)
    );

    assign dout     = tx_bit & frame_active;
    assign dout_oe  = frame_active;
    assign chan_sel = cfg_addr;
    assign coding   = cfg_code;

    // R1
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

endmodule

// File: tb/adc_port_resp_tb.sv
// Scoreboard bench: the frame driver queues expected result words, the
// monitor rebuilds each word from dout at the SCLK falls and compares.
module adc_port_resp_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [11:0] sample_data;
    logic        dout;
    logic        dout_oe;
    logic [1:0]  chan_sel;
    logic        coding;

    logic [11:0] samp [4];
    logic [15:0] exp_q [$];
    logic [1:0]  m_addr = 2'd0;
    logic        m_code = 1'b0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sample_data = samp[chan_sel];

    adc_port_resp u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .din         (din),
        .sample_data (sample_data),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .chan_sel    (chan_sel),
        .coding      (coding)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame; nfalls < 16 aborts it, extra adds falls after the 16th.
    task automatic run_frame(input logic wr, input logic [1:0] a, input logic c,
                             input logic [15:0] junk, input int nfalls, input int extra);
        logic [15:0] ctrl;
        logic [11:0] d;
        ctrl = junk & 16'h33DF;
        ctrl[15] = wr;
        ctrl[11:10] = a;
        ctrl[5] = c;
        d = samp[m_addr];
        if (m_code) d[11] = ~d[11];
        if (nfalls == 16) exp_q.push_back({2'b00, m_addr, d});
        @(negedge clk);
        cs_n = 1'b0;
        din  = ctrl[15];
        wait_clk(HALF);
        // R9: the sample changes after select fell; the result must not follow
        samp[m_addr] = samp[m_addr] + 12'h111;
        for (int i = 0; i < nfalls; i++) begin
            sclk = 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
            if (i < 15) din = ctrl[14-i];
            wait_clk(HALF);
        end
        if (nfalls == 16) check("R7 oe after 16th fall", 32'(dout_oe), 32'd0);
        for (int i = 0; i < extra; i++) begin
            din  = ~din;
            sclk = 1'b0;
            wait_clk(HALF);
            check("R12 oe during extra falls", 32'(dout_oe), 32'd0);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
        check("R1 oe with select high", {dout_oe, dout}, 32'd0);
        if (nfalls == 16 && wr) begin
            m_addr = a;
            m_code = c;
        end
        check("R5 R6 R8 stored channel", 32'(chan_sel), 32'(m_addr));
        check("R5 R6 R8 stored coding", 32'(coding), 32'(m_code));
        wait_clk(HALF);
    endtask

    // Monitor: rebuild each full frame from dout and compare with the queue.
    initial begin
        logic [15:0] word;
        logic [15:0] exp;
        int          nb;
        bit          oe_ok;
        forever begin
            @(negedge cs_n);
            nb = 0;
            word = '0;
            oe_ok = 1'b1;
            while (nb < 16) begin
                @(negedge sclk or posedge cs_n);
                if (cs_n) break;
                word = {word[14:0], dout};
                if (!dout_oe) oe_ok = 1'b0;
                nb++;
            end
            if (nb == 16) begin
                check("R2 oe held through frame", 32'(oe_ok), 32'd1);
                if (exp_q.size() == 0) begin
                    check("R3 unexpected frame", 32'(word), 32'hFFFF_FFFF);
                end else begin
                    exp = exp_q.pop_front();
                    check("R3 R9 R10 result word", 32'(word), 32'(exp));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        samp[0] = 12'h5A3;
        samp[1] = 12'h9C4;
        samp[2] = 12'h0F1;
        samp[3] = 12'hE27;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 R11 reset state
        check("R1 reset oe/dout", {dout_oe, dout}, 32'd0);
        check("R11 reset channel", 32'(chan_sel), 32'd0);
        check("R11 reset coding", 32'(coding), 32'd0);
        // R3 R4: read frame, then write channel 2 straight binary
        run_frame(1'b0, 2'd0, 1'b0, 16'h0000, 16, 0);
        run_frame(1'b1, 2'd2, 1'b0, 16'h0000, 16, 0);
        // R6: no write flag, field bits and ignored bits set
        run_frame(1'b0, 2'd1, 1'b1, 16'hFFFF, 16, 0);
        // R5 R10: write channel 3 two's complement, then read it back
        run_frame(1'b1, 2'd3, 1'b1, 16'h1234, 16, 0);
        run_frame(1'b0, 2'd0, 1'b0, 16'h0000, 16, 0);
        // R8: abort after 7 and after 15 falls, then a clean frame
        run_frame(1'b1, 2'd1, 1'b0, 16'h0000, 7, 0);
        run_frame(1'b1, 2'd0, 1'b0, 16'hFFFF, 15, 0);
        run_frame(1'b0, 2'd0, 1'b0, 16'h0000, 16, 0);
        // R12: extra falls after the 16th are ignored
        run_frame(1'b1, 2'd1, 1'b0, 16'h0000, 16, 3);
        run_frame(1'b0, 2'd2, 1'b1, 16'hAAAA, 16, 0);
        run_frame(1'b1, 2'd0, 1'b1, 16'h0000, 16, 0);
        run_frame(1'b0, 2'd0, 1'b0, 16'h0000, 16, 0);
        check("R3 all results delivered", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule